// File: doc/BRIEF.md
# Program Status Register Write Unit

This block keeps two 32-bit status words: the live status word and a single saved copy. It carries out move-to-status writes into either word and returns either word in full on a read port. The write operand is either a 32-bit register value or an 8-bit constant rotated right by an even amount.

Each write names one or both of two byte fields: a control byte at bits [7:0] and a flags byte at bits [31:24]. Only certain bit groups inside the selected fields are actually writable:

- the condition flags at bits [31:28];
- the state bit at bit 5;
- the interrupt-disable and mode group at bits 7, 6 and [3:0].

The mode and interrupt group of the live word is protected while the core runs in user mode. When a write to the live word changes its mode, a one-cycle strobe is raised together with the new 5-bit mode, so that surrounding logic can switch register banks.

Top module: `psr_update_unit`

## Requirements
- R1: After reset the live word reads 0x000000D3 (supervisor mode 5'b10011, both interrupt-disable bits 7 and 6 set), the saved word reads 0x00000010, the strobe is low and the reported mode is 5'b10011.
- R2: The write mask is built from the two field selects. The control select opens bits [7:0] and the flags select opens bits [31:24]. A write that selects neither field leaves the live word unchanged.
- R3: A live write with the flags field selected copies operand bits [31:28] into the live word. Bits [27:8] of the live word never change.
- R4: A live write with the control field selected copies operand bit 5 into the live word, whatever the privilege mode.
- R5: A live write with the control field selected, while the privilege input is not user mode (5'b10000), copies operand bits 7, 6 and [3:0] and forces bit 4 to 1.
- R6: While the privilege input is user mode, bits 7, 6 and [4:0] of the live word keep their value on every write.
- R7: When the immediate form is chosen, the operand is the 8-bit constant zero-extended to 32 bits and rotated right by twice the 4-bit rotate field.
- R8: A write to the saved word replaces the bits in (field mask AND 0xF00000EF) with operand bits, keeps all other bits, and sets bit 4. Such a write leaves the live word unchanged.
- R9: The read port returns the full live word when the target select is 0 and the full saved word when it is 1.
- R10: With the write strobe low, neither word changes, whatever the other inputs are.
- R11: A write becomes visible on the clock edge that samples the strobe. The mode-change strobe is high for exactly that one following cycle, and only if bits [4:0] of the live word actually changed. The reported mode then equals the new bits [4:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| tgt_saved | input | 1 | 0 selects the live word, 1 selects the saved word (for both writes and reads) |
| fld_ctrl | input | 1 | Select the control byte [7:0] |
| fld_flags | input | 1 | Select the flags byte [31:24] |
| use_imm | input | 1 | 1 selects the rotated constant as operand, 0 selects reg_operand |
| reg_operand | input | 32 | Register operand |
| imm_val | input | 8 | 8-bit constant |
| imm_rot | input | 4 | Rotate field; rotate amount is twice this value |
| priv_mode | input | 5 | Current privilege mode; 5'b10000 is user |
| cur_psr | output | 32 | Live status word |
| saved_psr | output | 32 | Saved status word |
| rd_data | output | 32 | Read port, the word chosen by tgt_saved |
| mode_chg | output | 1 | One-cycle pulse when the live mode changed |
| new_mode | output | 5 | Mode reported with the last pulse |

## Verification
The assertions assume that `priv_mode` is a legal 5-bit mode whose bit 4 is set. They also assume that inputs are stable around the rising edge, so that the value sampled with the strobe is the value that the word should take next.

The stimulus drives every input on the falling edge and only uses defined mode encodings for the privilege input. It keeps the privilege input independent of the live word, so that the user-mode protection is exercised even while the word itself shows another mode.

// File: rtl/psr_pkg.sv
package psr_pkg;
    localparam int PSR_W  = 32;
    localparam int MODE_W = 5;
    localparam int IMM_W  = 8;
    localparam int ROT_W  = 4;
    localparam int BYTE_W = 8;
    localparam int NBYTES = PSR_W / BYTE_W;
    localparam int MODE_FORCE_BIT = 4;

    localparam logic [PSR_W-1:0] GRP_COND  = 32'hF000_0000;
    localparam logic [PSR_W-1:0] GRP_STATE = 32'h0000_0020;
    localparam logic [PSR_W-1:0] GRP_PRIV  = 32'h0000_00CF;
    localparam logic [PSR_W-1:0] GRP_ALL   = GRP_COND | GRP_STATE | GRP_PRIV;

    localparam logic [MODE_W-1:0] MODE_USER = 5'b10000;
    localparam logic [MODE_W-1:0] MODE_SVC  = 5'b10011;

    localparam logic [PSR_W-1:0] CUR_RESET   = 32'h0000_00D3;
    localparam logic [PSR_W-1:0] SAVED_RESET = 32'h0000_0010;

    typedef struct packed {
        logic [PSR_W-1:0]  cur;
        logic [PSR_W-1:0]  saved;
        logic              chg;
        logic [MODE_W-1:0] mode;
    } psr_state_t;
endpackage

// File: rtl/psr_operand_gen.sv
module psr_operand_gen #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4
) (
    input  logic              use_imm,
    input  logic [DATA_W-1:0] reg_operand,
    input  logic [IMM_W-1:0]  imm_val,
    input  logic [ROT_W-1:0]  imm_rot,
    output logic [DATA_W-1:0] operand
);
    localparam int AMT_W = ROT_W + 1;

    logic [DATA_W-1:0]   imm_ext;
    logic [2*DATA_W-1:0] imm_dbl;
    logic [AMT_W-1:0]    amt;

    always_comb begin
        imm_ext = {{(DATA_W-IMM_W){1'b0}}, imm_val};
        amt     = {imm_rot, 1'b0};
        imm_dbl = {imm_ext, imm_ext} >> amt;
        operand = use_imm ? imm_dbl[DATA_W-1:0] : reg_operand;
    end
endmodule

// File: rtl/psr_field_mask.sv
module psr_field_mask
    import psr_pkg::*;
(
    input  logic              fld_ctrl,
    input  logic              fld_flags,
    input  logic [MODE_W-1:0] priv_mode,
    output logic [PSR_W-1:0]  cur_mask,
    output logic [PSR_W-1:0]  cur_force,
    output logic [PSR_W-1:0]  sav_mask,
    output logic [PSR_W-1:0]  sav_force
);
    logic [PSR_W-1:0] field_mask;
    logic             priv_ok;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        if (b == 0) begin : g_ctrl
            assign field_mask[b*BYTE_W +: BYTE_W] = {BYTE_W{fld_ctrl}};
        end else if (b == NBYTES-1) begin : g_flags
            assign field_mask[b*BYTE_W +: BYTE_W] = {BYTE_W{fld_flags}};
        end else begin : g_none
            assign field_mask[b*BYTE_W +: BYTE_W] = '0;
        end
    end

    always_comb begin
        priv_ok   = (priv_mode != MODE_USER);
        cur_mask  = field_mask & (GRP_COND | GRP_STATE | (priv_ok ? GRP_PRIV : '0));
        cur_force = (priv_ok && fld_ctrl) ? (PSR_W'(1) << MODE_FORCE_BIT) : '0;
        sav_mask  = field_mask & GRP_ALL;
        sav_force = PSR_W'(1) << MODE_FORCE_BIT;
    end
endmodule

// File: rtl/psr_merge.sv
module psr_merge #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] mask,
    input  logic [DATA_W-1:0] force_set,
    output logic [DATA_W-1:0] new_val
);
    always_comb begin
        new_val = (old_val & ~mask) | (operand & mask) | force_set;
    end
endmodule

// File: rtl/psr_update_unit.sv
module psr_update_unit
    import psr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              tgt_saved,
    input  logic              fld_ctrl,
    input  logic              fld_flags,
    input  logic              use_imm,
    input  logic [PSR_W-1:0]  reg_operand,
    input  logic [IMM_W-1:0]  imm_val,
    input  logic [ROT_W-1:0]  imm_rot,
    input  logic [MODE_W-1:0] priv_mode,
    output logic [PSR_W-1:0]  cur_psr,
    output logic [PSR_W-1:0]  saved_psr,
    output logic [PSR_W-1:0]  rd_data,
    output logic              mode_chg,
    output logic [MODE_W-1:0] new_mode
);
    psr_state_t st_d, st_q;

    logic [PSR_W-1:0] operand;
    logic [PSR_W-1:0] cur_mask, cur_force, sav_mask, sav_force;
    logic [PSR_W-1:0] cur_next, sav_next;

    psr_operand_gen #(.DATA_W(PSR_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_opgen (
        .use_imm     (use_imm),
        .reg_operand (reg_operand),
        .imm_val     (imm_val),
        .imm_rot     (imm_rot),
        .operand     (operand)
    );

    psr_field_mask u_mask (
        .fld_ctrl  (fld_ctrl),
        .fld_flags (fld_flags),
        .priv_mode (priv_mode),
        .cur_mask  (cur_mask),
        .cur_force (cur_force),
        .sav_mask  (sav_mask),
        .sav_force (sav_force)
    );

    psr_merge #(.DATA_W(PSR_W)) u_merge_cur (
        .old_val   (st_q.cur),
        .operand   (operand),
        .mask      (cur_mask),
        .force_set (cur_force),
        .new_val   (cur_next)
    );

    psr_merge #(.DATA_W(PSR_W)) u_merge_sav (
        .old_val   (st_q.saved),
        .operand   (operand),
        .mask      (sav_mask),
        .force_set (sav_force),
        .new_val   (sav_next)
    );

    always_comb begin
        st_d     = st_q;
        st_d.chg = 1'b0;
        if (wr_en) begin
            if (tgt_saved) begin
                st_d.saved = sav_next;
            end else begin
                st_d.cur = cur_next;
                if (cur_next[MODE_W-1:0] != st_q.cur[MODE_W-1:0]) begin
                    st_d.chg  = 1'b1;
                    st_d.mode = cur_next[MODE_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cur   <= CUR_RESET;
            st_q.saved <= SAVED_RESET;
            st_q.chg   <= 1'b0;
            st_q.mode  <= MODE_SVC;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_psr   = st_q.cur;
    assign saved_psr = st_q.saved;
    assign rd_data   = tgt_saved ? st_q.saved : st_q.cur;
    assign mode_chg  = st_q.chg;
    assign new_mode  = st_q.mode;
endmodule

// File: rtl/psr_update_checker.sv
module psr_update_checker
    import psr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              tgt_saved,
    input logic [MODE_W-1:0] priv_mode,
    input logic [PSR_W-1:0]  cur_psr,
    input logic [PSR_W-1:0]  saved_psr,
    input logic              mode_chg,
    input logic [MODE_W-1:0] new_mode
);
    a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(cur_psr) && $stable(saved_psr) && !mode_chg));

    a_r6_user_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !tgt_saved && priv_mode == MODE_USER)
        |=> (cur_psr[7:0] & 8'hDF) == ($past(cur_psr[7:0]) & 8'hDF));

    a_r8_saved_leaves_live: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tgt_saved) |=> ($stable(cur_psr) && !mode_chg));

    a_r8_saved_bit4_set: assert property (@(posedge clk) disable iff (!rst_n)
        saved_psr[4]);

    a_r3_mid_bits_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(cur_psr[27:8]));

    a_r11_strobe_means_change: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |-> (new_mode == cur_psr[4:0] && cur_psr[4:0] != $past(cur_psr[4:0])));

    a_r11_change_raises_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_psr[4:0] != $past(cur_psr[4:0])) |-> mode_chg);
endmodule

bind psr_update_unit psr_update_checker u_psr_update_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .tgt_saved (tgt_saved),
    .priv_mode (priv_mode),
    .cur_psr   (cur_psr),
    .saved_psr (saved_psr),
    .mode_chg  (mode_chg),
    .new_mode  (new_mode)
);

// File: tb/test_psr_update_unit.sv
module test_psr_update_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        tgt_saved = 1'b0;
    logic        fld_ctrl = 1'b0;
    logic        fld_flags = 1'b0;
    logic        use_imm = 1'b0;
    logic [31:0] reg_operand = '0;
    logic [7:0]  imm_val = '0;
    logic [3:0]  imm_rot = '0;
    logic [4:0]  priv_mode = 5'b10011;
    logic [31:0] cur_psr, saved_psr, rd_data;
    logic        mode_chg;
    logic [4:0]  new_mode;

    localparam logic [4:0] USR = 5'b10000;
    localparam logic [4:0] SVC = 5'b10011;

    typedef struct {
        logic [31:0] cur;
        logic [31:0] sav;
        logic [31:0] rd;
        logic        chg;
        logic [4:0]  mode;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          drv_done = 1'b0;
    bit          finished = 1'b0;
    logic [31:0] m_cur = 32'h0000_00D3;
    logic [31:0] m_sav = 32'h0000_0010;

    always #5 clk = ~clk;

    psr_update_unit i_psr_update_unit (
        .clk, .rst_n, .wr_en, .tgt_saved, .fld_ctrl, .fld_flags, .use_imm,
        .reg_operand, .imm_val, .imm_rot, .priv_mode,
        .cur_psr, .saved_psr, .rd_data, .mode_chg, .new_mode
    );

    task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%08h expected=%08h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Drive one cycle and push the expected post-edge state (bench model of R2..R11).
    task automatic drive(string tag, bit we, bit sav, bit fc, bit ff, bit imm,
                         logic [31:0] rop, logic [7:0] iv, logic [3:0] ir, logic [4:0] pm);
        exp_t        e;
        logic [31:0] op;
        logic [4:0]  old_mode;
        @(negedge clk);
        wr_en = we; tgt_saved = sav; fld_ctrl = fc; fld_flags = ff; use_imm = imm;
        reg_operand = rop; imm_val = iv; imm_rot = ir; priv_mode = pm;
        op = rop;
        if (imm) begin
            op = {24'h0, iv};
            for (int i = 0; i < 2 * ir; i++) op = {op[0], op[31:1]};
        end
        old_mode = m_cur[4:0];
        e.chg = 1'b0;
        e.mode = 5'b0;
        if (we) begin
            if (!sav) begin
                if (ff) m_cur[31:28] = op[31:28];
                if (fc) begin
                    m_cur[5] = op[5];
                    if (pm != USR) begin
                        m_cur[7:6] = op[7:6];
                        m_cur[3:0] = op[3:0];
                        m_cur[4]   = 1'b1;
                    end
                end
                if (m_cur[4:0] != old_mode) begin
                    e.chg = 1'b1;
                    e.mode = m_cur[4:0];
                end
            end else begin
                if (ff) m_sav[31:28] = op[31:28];
                if (fc) begin
                    m_sav[7:5] = op[7:5];
                    m_sav[3:0] = op[3:0];
                end
                m_sav[4] = 1'b1;
            end
        end
        e.cur = m_cur;
        e.sav = m_sav;
        e.rd  = sav ? m_sav : m_cur;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                cmp(e.tag, "live word", cur_psr, e.cur);
                cmp(e.tag, "saved word", saved_psr, e.sav);
                cmp({e.tag, "/R9"}, "read port", rd_data, e.rd);
                cmp({e.tag, "/R11"}, "mode strobe", {31'b0, mode_chg}, {31'b0, e.chg});
                if (e.chg) cmp({e.tag, "/R11"}, "new mode", {27'b0, new_mode}, {27'b0, e.mode});
            end
        end
    end

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        cmp("R1", "live word", cur_psr, 32'h0000_00D3);
        cmp("R1", "saved word", saved_psr, 32'h0000_0010);
        cmp("R1", "mode strobe", {31'b0, mode_chg}, 32'h0);
        cmp("R1", "mode", {27'b0, new_mode}, {27'b0, SVC});
        rst_n = 1'b1;
        // R10: strobe low, everything else active
        drive("R10", 0, 0, 1, 1, 0, 32'hFFFF_FFFF, 8'h00, 4'h0, SVC);
        drive("R10", 0, 1, 1, 1, 0, 32'h0000_0000, 8'h00, 4'h0, SVC);
        // R3: flags field, bits 27:24 stay
        drive("R3", 1, 0, 0, 1, 0, 32'hA5FF_FFFF, 8'h00, 4'h0, SVC);
        // R5: control field, switch to mode 1F, state bit 0
        drive("R5", 1, 0, 1, 0, 0, 32'h0000_001F, 8'h00, 4'h0, SVC);
        // R11: strobe must drop next cycle
        drive("R11", 0, 0, 0, 0, 0, 32'h0, 8'h00, 4'h0, SVC);
        // R11: same mode written, no strobe
        drive("R11", 1, 0, 1, 0, 0, 32'h0000_001F, 8'h00, 4'h0, SVC);
        // R4: state bit set
        drive("R4", 1, 0, 1, 0, 0, 32'h0000_003F, 8'h00, 4'h0, SVC);
        // R5: bit 4 forced to 1 from operand 0x02
        drive("R5", 1, 0, 1, 0, 0, 32'h0000_0002, 8'h00, 4'h0, SVC);
        // R6: user mode cannot touch mode/interrupt bits, flags and state still move
        drive("R6", 1, 0, 1, 1, 0, 32'h5000_00C0, 8'h00, 4'h0, USR);
        drive("R6", 1, 0, 1, 0, 0, 32'h0000_001B, 8'h00, 4'h0, USR);
        // R2: no field selected
        drive("R2", 1, 0, 0, 0, 0, 32'hFFFF_FFFF, 8'h00, 4'h0, SVC);
        // R7: immediate forms
        drive("R7", 1, 0, 0, 1, 1, 32'h0, 8'hF0, 4'h4, SVC);
        drive("R7", 1, 0, 1, 0, 1, 32'hFFFF_FFFF, 8'h13, 4'h0, SVC);
        drive("R7", 1, 0, 1, 0, 1, 32'h0, 8'h3C, 4'hF, SVC);
        drive("R7", 1, 0, 0, 1, 1, 32'h0, 8'h01, 4'h1, SVC);
        // R8: saved word writes
        drive("R8", 1, 1, 1, 1, 0, 32'hFFFF_FFFF, 8'h00, 4'h0, USR);
        drive("R8", 1, 1, 1, 0, 0, 32'h0000_0000, 8'h00, 4'h0, SVC);
        drive("R8", 1, 1, 0, 0, 0, 32'h0000_0000, 8'h00, 4'h0, SVC);
        drive("R8", 1, 1, 0, 1, 1, 32'h0, 8'h05, 4'h2, SVC);
        // R9: read both targets with no write
        drive("R9", 0, 1, 0, 0, 0, 32'h0, 8'h00, 4'h0, SVC);
        drive("R9", 0, 0, 0, 0, 0, 32'h0, 8'h00, 4'h0, SVC);
        // Back-to-back mode changes, R11
        drive("R11", 1, 0, 1, 0, 0, 32'h0000_0013, 8'h00, 4'h0, SVC);
        drive("R11", 1, 0, 1, 0, 0, 32'h0000_0012, 8'h00, 4'h0, SVC);
        drive("R11", 0, 0, 0, 0, 0, 32'h0, 8'h00, 4'h0, SVC);
        drv_done = 1'b1;
        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
        finish_run();
    end
endmodule